// File: doc/BRIEF.md
# Audio Serial Clock Ratio Monitor

This block watches the master clock, bit clock and frame clock of a serial audio input and flags any frame whose clock ratios are wrong. It runs on the master clock. The bit clock and the frame clock enter through two-flop synchronizers. A frame boundary is the falling edge of the synchronized frame clock. At each boundary the block compares the number of master-clock cycles and the number of bit-clock rising edges in the frame just finished against parameterised targets. It also compares the master-clock count with the previous frame's count, to catch a frame that drifts.

Every fault sets a sticky bit in an 8-bit status word. A phase-lock fault flag and a clipping flag arrive from outside and are latched into the same word. A host clears the word by writing to its address. The `valid` output stays high only while the word reads zero. The clocks may run while reset is asserted. The incomplete frame that is in progress when reset is released is never judged.

Top module: `audio_clk_monitor`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `status` reads 0x00 and `valid` reads 1, even with all clocks toggling.
- R2: Frames of exactly MCLK_PER_FRAME (256) master cycles that each hold exactly SCLK_PER_FRAME (64) bit-clock rising edges leave `status` at 0x00.
- R3: A frame whose master-cycle count differs from MCLK_PER_FRAME sets bit 4 of `status`.
- R4: A frame whose count of bit-clock rising edges differs from SCLK_PER_FRAME sets bit 5 of `status`.
- R5: If a frame's master-cycle count differs from the previous complete frame's count by more than SLIP_TOL (10), bit 3 of `status` is set. A difference of exactly 10 leaves bit 3 clear.
- R6: Any cycle in which `pll_err` is high sets bit 6. Any cycle in which `clip` is high sets bit 7.
- R7: Set bits stay set after their cause is gone, until the host clears them. Bits 2 to 0 always read 0.
- R8: A cycle with `wr_en` high and `wr_addr` equal to STATUS_ADDR (0x02) clears every status bit. A write to any other address leaves `status` unchanged.
- R9: A fault present in the same cycle as a clearing write wins, and its bit reads 1 afterwards.
- R10: `valid` is 1 exactly when `status` is 0x00.
- R11: The first frame boundary after reset only starts measurement. The partial frame before it raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Bit clock, asynchronous to the block |
| lrclk | input | 1 | Frame clock; its falling edge ends a frame |
| pll_err | input | 1 | External phase-lock fault flag, level |
| clip | input | 1 | External clipping flag, level |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host write address |
| status | output | 8 | Sticky fault word: bit 7 clip, 6 phase lock, 5 bit clock, 4 frame length, 3 slip |
| valid | output | 1 | High while no fault bit is set |

## Verification
A wrong frame counter, or a wrong previous-frame register, appears at `status` about three master cycles after the falling frame-clock edge that closes the affected frame. The synchronizer adds two of those cycles, and the status register adds one more. A measurement that arms one frame early shows up as a spurious bit 4 straight after reset. A broken clear or a broken priority shows up on `status` on the clock edge that follows the write. The directed scenarios place frame lengths on both sides of the slip tolerance, so that an off-by-one in the comparison changes the reported bit pattern.

// File: rtl/audio_clk_monitor.sv
module audio_clk_monitor #(
  parameter int MCLK_PER_FRAME = 256,
  parameter int SCLK_PER_FRAME = 64,
  parameter int SLIP_TOL       = 10,
  parameter int AW             = 8,
  parameter int STATUS_ADDR    = 2
) (
  input  logic          mclk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          lrclk,
  input  logic          pll_err,
  input  logic          clip,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic [7:0]    status,
  output logic          valid
);
  localparam int MCW = $clog2(MCLK_PER_FRAME) + 2;
  localparam int SCW = $clog2(SCLK_PER_FRAME) + 2;
  localparam logic [MCW-1:0] M_EXP = MCW'(MCLK_PER_FRAME);
  localparam logic [SCW-1:0] S_EXP = SCW'(SCLK_PER_FRAME);
  localparam logic [MCW-1:0] M_TOL = MCW'(SLIP_TOL);
  localparam logic [AW-1:0]  ADDR  = AW'(STATUS_ADDR);

  logic [2:0]     sclk_sy, lr_sy;
  logic           armed, have_prev;
  logic [MCW-1:0] mcnt, mprev, mdiff;
  logic [SCW-1:0] scnt;
  logic [4:0]     err_q, err_set;

  wire sclk_rise = sclk_sy[1] & ~sclk_sy[2];
  wire lr_fall   = ~lr_sy[1] & lr_sy[2];
  wire judge     = lr_fall & armed;
  wire wr_hit    = wr_en && (wr_addr == ADDR);

  assign mdiff = (mcnt > mprev) ? mcnt - mprev : mprev - mcnt;

  assign err_set = {clip,
                    pll_err,
                    judge && (scnt != S_EXP),
                    judge && (mcnt != M_EXP),
                    judge && have_prev && (mdiff > M_TOL)};

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      lr_sy   <= '0;
    end else begin
      sclk_sy <= {sclk_sy[1:0], sclk};
      lr_sy   <= {lr_sy[1:0], lrclk};
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      have_prev <= 1'b0;
      mcnt      <= '0;
      mprev     <= '0;
      scnt      <= '0;
    end else if (lr_fall) begin
      armed <= 1'b1;
      if (armed) begin
        have_prev <= 1'b1;
        mprev     <= mcnt;
      end
      mcnt <= MCW'(1);
      scnt <= SCW'(sclk_rise);
    end else begin
      if (~&mcnt) mcnt <= mcnt + 1'b1;
      if (sclk_rise && ~&scnt) scnt <= scnt + 1'b1;
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (wr_hit ? 5'd0 : err_q) | err_set;
  end

  assign status = {err_q, 3'b000};
  assign valid  = ~|err_q;
endmodule

module audio_clk_monitor_chk #(
  parameter int AW          = 8,
  parameter int STATUS_ADDR = 2
) (
  input logic          mclk,
  input logic          rst_n,
  input logic          pll_err,
  input logic          clip,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          lr_fall,
  input logic [7:0]    status,
  input logic          valid
);
  localparam logic [AW-1:0] ADDR = AW'(STATUS_ADDR);

  AST_STICKY_HOLD: assert property (@(posedge mclk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR) |=> ((status & $past(status)) == $past(status))); // R7

  AST_CLEAR_ALL: assert property (@(posedge mclk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR && !pll_err && !clip && !lr_fall) |=> (status == 8'h00)); // R8

  AST_PLL_LATCH: assert property (@(posedge mclk) disable iff (!rst_n)
    pll_err |=> status[6]); // R9

  AST_CLIP_LATCH: assert property (@(posedge mclk) disable iff (!rst_n)
    clip |=> status[7]); // R6

  AST_VALID_CLEAN: assert property (@(posedge mclk) disable iff (!rst_n)
    valid == (status == 8'h00)); // R10
endmodule

bind audio_clk_monitor audio_clk_monitor_chk #(.AW(AW), .STATUS_ADDR(STATUS_ADDR)) u_chk (
  .mclk(mclk), .rst_n(rst_n), .pll_err(pll_err), .clip(clip),
  .wr_en(wr_en), .wr_addr(wr_addr), .lr_fall(lr_fall),
  .status(status), .valid(valid)
);

// File: tb/audio_clk_monitor_test.sv
module audio_clk_monitor_test;
  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, lrclk = 1'b1;
  logic       pll_err = 1'b0, clip = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] status;
  logic       valid;

  int n_chk = 0, n_bad = 0;
  int pos = 0, rcnt = 0, np = 0;
  int len_v = 256, cap_v = 64;

  audio_clk_monitor uut (
    .mclk(mclk), .rst_n(rst_n), .sclk(sclk), .lrclk(lrclk),
    .pll_err(pll_err), .clip(clip), .wr_en(wr_en), .wr_addr(wr_addr),
    .status(status), .valid(valid)
  );

  always #4 mclk = ~mclk;

  always @(negedge mclk) begin
    np = (pos >= len_v - 1) ? 0 : pos + 1;
    pos   <= np;
    lrclk <= (np < 128);
    if (np == 128) rcnt <= 0;
    if (np % 4 == 2 && rcnt < cap_v) begin
      sclk <= 1'b1;
      rcnt <= rcnt + 1;
    end else if (np % 4 == 0) sclk <= 1'b0;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input logic [7:0] exp);
    chk({tag, " status"}, status, exp);
    chk({tag, " valid"}, {7'd0, valid}, {7'd0, exp == 8'h00});
  endtask

  task automatic run_frame(input int len, input int cap);
    while (pos != 128) @(negedge mclk);
    len_v = len;
    cap_v = cap;
    @(negedge mclk);
    while (pos != 128) @(negedge mclk);
    len_v = 256;
    cap_v = 64;
    cyc(6);
  endtask

  task automatic host_write(input logic [7:0] a);
    wr_addr = a;
    wr_en   = 1'b1;
    @(negedge mclk);
    wr_en   = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset;
    cyc(300);
    chk_state("R1 held in reset", 8'h00);
    while (pos != 40) @(negedge mclk);
    rst_n = 1'b1;
    cyc(2);
    chk_state("R1 after release", 8'h00);
    run_frame(256, 64);
    chk_state("R11 partial frame ignored", 8'h00);
    run_frame(256, 64);
    run_frame(256, 64);
    chk_state("R2 nominal frames", 8'h00);
  endtask

  task automatic t_sclk;
    run_frame(256, 63);
    chk_state("R4 one bit clock missing", 8'h20);
    run_frame(256, 64);
    chk_state("R7 sticky after good frame", 8'h20);
    host_write(8'h01);
    chk_state("R8 write other address ignored", 8'h20);
    host_write(8'h02);
    chk_state("R8 write clears", 8'h00);
  endtask

  task automatic t_lr;
    run_frame(264, 64);
    chk_state("R3 long frame, no slip", 8'h10);
    host_write(8'h02);
    run_frame(256, 64);
    run_frame(250, 64);
    chk_state("R3 R4 short frame", 8'h30);
    host_write(8'h02);
    run_frame(256, 64);
  endtask

  task automatic t_slip;
    run_frame(266, 64);
    chk_state("R5 difference of ten", 8'h10);
    host_write(8'h02);
    run_frame(256, 64);
    chk_state("R5 return by ten", 8'h00);
    run_frame(267, 64);
    chk_state("R5 difference of eleven", 8'h18);
    run_frame(256, 64);
    host_write(8'h02);
    chk_state("R5 cleared", 8'h00);
  endtask

  task automatic t_flags;
    cyc(3);
    pll_err = 1'b1;
    cyc(2);
    chk_state("R6 lock flag latched", 8'h40);
    host_write(8'h02);
    chk_state("R9 fault beats clear", 8'h40);
    pll_err = 1'b0;
    cyc(3);
    chk_state("R7 lock bit sticky", 8'h40);
    host_write(8'h02);
    chk_state("R8 clear lock bit", 8'h00);
    clip = 1'b1;
    cyc(1);
    clip = 1'b0;
    cyc(3);
    chk_state("R6 clip pulse latched", 8'h80);
    chk("R7 low bits zero", {5'd0, status[2:0]}, 8'h00);
    host_write(8'h02);
    chk_state("R10 valid restored", 8'h00);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_sclk;
        t_lr;
        t_slip;
        t_flags;
      end
      begin
        cyc(150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule